// File: doc/BRIEF.md
# Multiphase Clock Divider

The block takes a fast master clock and produces four registered clock-enable lines. A decade prescaler runs first and divides the master clock by 1, 10 or 100. Its output ticks drive a phase sequencer. The sequencer spreads those ticks over the four lines as a two-, three- or four-phase clock. All four lines are used in every mode, so the reader decides which lines to use and nothing needs rewiring.

Each prescaled tick lasts N master cycles. In the three- and four-phase modes, each line therefore pulses once every N·M master cycles, where M is the number of phases. The two-phase mode instead gives a square clock on lines 0 and 2 and its complement on lines 1 and 3. The two select inputs may change while the block is running. On the edge that sees a change, all lines drop low and both counters clear. The block then runs one full prescale period in the new setting and starts again from phase 0. This keeps narrow pulses and overlaps off the outputs.

Top module: `mphase_clkdiv`

## Requirements
- R1: While `rst` is high at a clock edge, every output bit is 0 after that edge. Counting from the last edge with `rst` high, the outputs stay 0 for the next N−1 edges. At edge N they show phase 0 of the selected mode.
- R2: `div_sel` selects the prescale N: 00 gives 1, 01 gives 10, 10 gives 100. Once phase 0 is reached, the output word changes only at edges a multiple of N after the restart edge, and it then holds for exactly N edges.
- R3: The value 11 on `div_sel` acts exactly like 00, and 11 on `ph_sel` acts exactly like 00. Moving between 11 and 00 does not count as a change.
- R4: `ph_sel` 00 selects two-phase mode. Phase 0 drives `ph_out` to 4'b0101 and phase 1 drives it to 4'b1010. The two phases alternate, so lines 0 and 2 carry a clock with a period of 2N cycles and lines 1 and 3 carry its complement.
- R5: `ph_sel` 01 selects three-phase mode. Phase p (0, 1, 2) drives only bit p high, the phases rotate 0, 1, 2, 0, and bit 3 is always 0.
- R6: `ph_sel` 10 selects four-phase mode. Phase p (0 to 3) drives only bit p high, in strict rotation 0, 1, 2, 3, 0.
- R7: In three- and four-phase modes, at most one output bit is ever high, including across restarts.
- R8: On the first edge where either select, after the rule of R3, differs from the setting in use, all outputs go to 0 and both counters clear. The block then follows the R1 timing, counted from that edge, in the new setting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| div_sel | input | 2 | Prescale select (00: 1, 01: 10, 10: 100, 11: as 00) |
| ph_sel | input | 2 | Phase mode select (00: two, 01: three, 10: four, 11: as 00) |
| ph_out | output | 4 | Registered phased clock-enable lines |

## Verification
Two things can happen on the same edge: the prescaler can complete a tick while a select change arrives and forces a restart. The bench provokes this by changing settings at arbitrary cycle counts. That includes the edges where a tick is due and bursts of changes a few cycles apart. A cycle-by-cycle arithmetic model, driven by its own count of cycles since the last restart, judges every cycle. The restart must win: the outputs must go to 0 rather than advance to the next phase.

// File: rtl/mphase_clkdiv.sv
module mphase_clkdiv #(
  parameter int DIV_MID = 10,
  parameter int DIV_HI  = 100
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] div_sel,
  input  logic [1:0] ph_sel,
  output logic [3:0] ph_out
);
  localparam int CW = $clog2(DIV_HI);

  logic [1:0]    div_n, ph_n, div_q, ph_q;
  logic [CW-1:0] pre_cnt, pre_last;
  logic [1:0]    step, step_last, step_nx;
  logic [3:0]    pat;
  logic          run, tick, restart;

  assign div_n = (div_sel == 2'b11) ? 2'b00 : div_sel;
  assign ph_n  = (ph_sel  == 2'b11) ? 2'b00 : ph_sel;

  always_comb begin
    case (div_q)
      2'b01:   pre_last = CW'(DIV_MID - 1);
      2'b10:   pre_last = CW'(DIV_HI - 1);
      default: pre_last = '0;
    endcase
  end

  always_comb begin
    case (ph_q)
      2'b01:   step_last = 2'd2;
      2'b10:   step_last = 2'd3;
      default: step_last = 2'd1;
    endcase
  end

  assign tick    = (pre_cnt == pre_last);
  assign restart = rst | (div_n != div_q) | (ph_n != ph_q);
  assign step_nx = !run ? 2'd0 : ((step == step_last) ? 2'd0 : step + 2'd1);

  always_comb begin
    case (ph_q)
      2'b01, 2'b10: pat = 4'b0001 << step_nx;
      default:      pat = step_nx[0] ? 4'b1010 : 4'b0101;
    endcase
  end

  always_ff @(posedge clk) begin
    if (restart) begin
      div_q   <= div_n;
      ph_q    <= ph_n;
      pre_cnt <= '0;
      step    <= 2'd0;
      run     <= 1'b0;
      ph_out  <= 4'b0000;
    end else begin
      pre_cnt <= tick ? '0 : pre_cnt + 1'b1;
      if (tick) begin
        run    <= 1'b1;
        step   <= step_nx;
        ph_out <= pat;
      end
    end
  end
endmodule

module mphase_clkdiv_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] div_sel,
  input logic [1:0] ph_sel,
  input logic [1:0] ph_q,
  input logic [3:0] ph_out
);
  logic       seen;
  logic [3:0] prev_out;
  logic [1:0] prev_ph;
  logic [1:0] ph_eff;

  assign ph_eff = (ph_sel == 2'b11) ? 2'b00 : ph_sel;

  always_ff @(posedge clk) begin
    seen     <= !rst;
    prev_out <= ph_out;
    prev_ph  <= ph_q;
  end

  // R1
  reset_low_chk: assert property (@(posedge clk) rst |=> ph_out == 4'b0000);

  // R8
  change_low_chk: assert property (@(posedge clk) disable iff (rst)
    (seen && ph_eff != ph_q) |=> ph_out == 4'b0000);

  // R7
  at_most_one_chk: assert property (@(posedge clk) disable iff (rst)
    (seen && ph_q != 2'b00) |-> $onehot0(ph_out));

  // R5
  line3_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (seen && ph_q == 2'b01) |-> !ph_out[3]);

  // R4
  two_phase_shape_chk: assert property (@(posedge clk) disable iff (rst)
    (seen && ph_q == 2'b00 && ph_out != 4'b0000) |->
      (ph_out == 4'b0101 || ph_out == 4'b1010));

  // R6
  four_rotate_chk: assert property (@(posedge clk) disable iff (rst)
    (seen && ph_q == 2'b10 && prev_ph == 2'b10 && prev_out != 4'b0000 && ph_out != 4'b0000) |->
      (ph_out == prev_out || ph_out == {prev_out[2:0], prev_out[3]}));
endmodule

bind mphase_clkdiv mphase_clkdiv_chk i_chk (
  .clk(clk), .rst(rst), .div_sel(div_sel), .ph_sel(ph_sel),
  .ph_q(ph_q), .ph_out(ph_out)
);

// File: tb/test_mphase_clkdiv.sv
module test_mphase_clkdiv;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] div_sel = 2'b00;
  logic [1:0] ph_sel = 2'b00;
  logic [3:0] ph_out;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  int bd = 0, bp = 0, k = 0;
  bit from_rst = 1;

  always #2.5 clk = ~clk;

  mphase_clkdiv i_mphase_clkdiv (
    .clk(clk), .rst(rst), .div_sel(div_sel), .ph_sel(ph_sel), .ph_out(ph_out)
  );

  function automatic int norm(input logic [1:0] v);
    return (v == 2'b11) ? 0 : int'(v);
  endfunction

  function automatic int nval(input int d);
    return (d == 1) ? 10 : (d == 2) ? 100 : 1;
  endfunction

  function automatic logic [3:0] expect_out(input int d, input int p, input int kk);
    int n, m, idx;
    n = nval(d);
    m = (p == 1) ? 3 : (p == 2) ? 4 : 2;
    if (kk < n) return 4'b0000;
    idx = ((kk / n) - 1) % m;
    if (p == 0) return idx[0] ? 4'b1010 : 4'b0101;
    return 4'b0001 << idx;
  endfunction

  task automatic cyc();
    logic [3:0] e;
    string tag;
    @(posedge clk);
    if (rst || norm(div_sel) != bd || norm(ph_sel) != bp) begin
      bd = norm(div_sel); bp = norm(ph_sel); k = 0; from_rst = rst;
    end else k++;
    #1;
    e = expect_out(bd, bp, k);
    if (k < nval(bd)) tag = from_rst ? "R1" : "R8";
    else begin
      tag = (bp == 0) ? "R4" : (bp == 1) ? "R5" : "R6";
      tag = {tag, (div_sel == 2'b11 || ph_sel == 2'b11) ? " R3" : " R2"};
    end
    checks++;
    if (ph_out !== e) begin
      errors++;
      $display("FAIL %s: k=%0d actual=%b expected=%b", tag, k, ph_out, e);
    end
    if (bp != 0) begin
      checks++;
      if ($countones(ph_out) > 1) begin
        errors++;
        $display("FAIL R7: actual=%b expected at most one bit high", ph_out);
      end
    end
  endtask

  initial begin
    repeat (3) cyc();
    rst = 1'b0;
    for (int d = 0; d < 4; d++) begin
      for (int p = 0; p < 4; p++) begin
        div_sel = 2'(d); ph_sel = 2'(p);
        repeat (nval(norm(2'(d))) * 9 + 3) cyc();
      end
    end
    // R3: reserved and legal zero are the same setting
    div_sel = 2'b01; ph_sel = 2'b00; repeat (25) cyc();
    ph_sel = 2'b11; repeat (30) cyc();
    // R8: change lands on a tick edge and in bursts
    div_sel = 2'b01; ph_sel = 2'b10; repeat (29) cyc();
    ph_sel = 2'b01; repeat (4) cyc();
    div_sel = 2'b00; repeat (2) cyc();
    ph_sel = 2'b10; cyc();
    div_sel = 2'b10; repeat (250) cyc();
    for (int i = 0; i < 12; i++) begin
      ph_sel = 2'(i % 3); div_sel = 2'(i % 2);
      repeat (i + 1) cyc();
    end
    repeat (60) cyc();
    // R1: reset mid-run
    rst = 1'b1; repeat (2) cyc();
    rst = 1'b0; repeat (80) cyc();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule